// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Engine

This block computes a 16-bit cyclic redundancy check over a byte stream, folding one whole byte into the remainder on every clock where a byte is presented. It uses the generator polynomial x^16 + x^12 + x^5 + 1 (0x1021), no bit reflection, a zero starting value and no final inversion. Eight division steps become one lookup in a 256-word table of precomputed remainders. A constant function builds the table when the design is elaborated, so no memory image is loaded from outside.

A message begins with a start pulse, which empties the running remainder. The same cycle may also carry the first byte. Later bytes are fed with the valid strobe and may have idle gaps between them. The remainder register appears directly on the output. A sender appends the two result bytes, high byte first, to the message. A receiver that runs the same engine over the message and those two bytes ends with zero. Bytes must be fed in the same order on both sides. For a 16-bit word, that means high byte then low byte.

Top module: `crcb_engine`

## Requirements
- R1: While reset is high and in the cycle after it is released, `crc_out` is 0x0000.
- R2: Table entry j holds the remainder of j·x^16 divided by the generator. A single byte b fed with `msg_start` high gives `crc_out` equal to entry b one cycle later. The bytes 0x00, 0x01, 0x02 and 0x03 give 0x0000, 0x1021, 0x2042 and 0x3063.
- R3: When `byte_vld` is high and `msg_start` is low, the next remainder is built in two steps. The index is `byte_in` XOR the upper eight bits of the remainder. The next remainder is the remainder shifted left by eight and cut to 16 bits, XOR the table entry at that index. This equals eight MSB-first bit-serial division steps.
- R4: When both `byte_vld` and `msg_start` are low, `crc_out` keeps its value.
- R5: `msg_start` alone clears the remainder to 0x0000 on the next clock.
- R6: `msg_start` together with `byte_vld` discards the old remainder and processes `byte_in` from a zero start in that same cycle.
- R7: A message followed by its own result, high byte first then low byte, leaves a remainder of 0x0000.
- R8: The ASCII bytes "123456789" fed from a cleared start give 0x31C3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msg_start | input | 1 | Clears the remainder at the start of a message |
| byte_vld | input | 1 | `byte_in` carries a message byte this cycle |
| byte_in | input | 8 | Message byte |
| crc_out | output | 16 | Current remainder |

## Verification
The hardest case to reach is a start pulse that coincides with a valid byte while the register holds a nonzero remainder. Only in that case does a stale high byte that leaked into the index show up as a wrong result. The stimulus therefore builds a long nonzero remainder first, then fires start and byte together with varied byte values. A bit-serial reference model in the bench checks every cycle, including idle gaps and start-only cycles placed between bursts.

// File: rtl/crcb_pkg.sv
package crcb_pkg;

    localparam int unsigned CRC_W      = 16;
    localparam int unsigned SYM_W      = 8;
    localparam logic [CRC_W-1:0] GEN_POLY = 16'h1021;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_FOLD  = 2'd2
    } crcb_act_e;

    typedef struct packed {
        crcb_act_e        act;
        logic             fresh;
        logic [SYM_W-1:0] sym;
    } crcb_ctl_t;

    // Remainder of sym * x^w modulo the generator, by plain long division.
    function automatic logic [CRC_W-1:0] rem_entry(input logic [SYM_W-1:0] sym,
                                                   input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        r = {sym, {(CRC_W-SYM_W){1'b0}}};
        for (int k = 0; k < SYM_W; k++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ poly;
            else            r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/crcb_table_rom.sv
module crcb_table_rom
    import crcb_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = GEN_POLY
) (
    input  logic [SYM_W-1:0] idx,
    output logic [CRC_W-1:0] word
);
    localparam int unsigned DEPTH = 1 << SYM_W;

    logic [CRC_W-1:0] tbl [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        assign tbl[j] = rem_entry(SYM_W'(j), POLY);
    end

    assign word = tbl[idx];
endmodule

// File: rtl/crcb_step.sv
module crcb_step
    import crcb_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = GEN_POLY
) (
    input  logic [CRC_W-1:0] cur,
    input  logic             fresh,
    input  logic [SYM_W-1:0] sym,
    output logic [CRC_W-1:0] nxt
);
    localparam int unsigned KEEP_W = CRC_W - SYM_W;

    logic [CRC_W-1:0] base;
    logic [SYM_W-1:0] idx;
    logic [CRC_W-1:0] word;

    always_comb begin
        base = fresh ? '0 : cur;
        idx  = sym ^ base[CRC_W-1 -: SYM_W];
        nxt  = {base[KEEP_W-1:0], {SYM_W{1'b0}}} ^ word;
    end

    crcb_table_rom #(.POLY(POLY)) u_rom (
        .idx  (idx),
        .word (word)
    );
endmodule

// File: rtl/crcb_state.sv
module crcb_state
    import crcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  crcb_act_e        act,
    input  logic [CRC_W-1:0] nxt,
    output logic [CRC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= '0;
                ACT_FOLD:  q <= nxt;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/crcb_engine.sv
module crcb_engine
    import crcb_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = GEN_POLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_start,
    input  logic             byte_vld,
    input  logic [SYM_W-1:0] byte_in,
    output logic [CRC_W-1:0] crc_out
);
    crcb_ctl_t        ctl;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] rem_d;

    always_comb begin
        ctl.fresh = msg_start;
        ctl.sym   = byte_in;
        if (byte_vld)       ctl.act = ACT_FOLD;
        else if (msg_start) ctl.act = ACT_CLEAR;
        else                ctl.act = ACT_HOLD;
    end

    crcb_step #(.POLY(POLY)) u_step (
        .cur   (rem_q),
        .fresh (ctl.fresh),
        .sym   (ctl.sym),
        .nxt   (rem_d)
    );

    crcb_state u_state (
        .clk (clk),
        .rst (rst),
        .act (ctl.act),
        .nxt (rem_d),
        .q   (rem_q)
    );

    assign crc_out = rem_q;
endmodule

// File: rtl/crcb_engine_chk.sv
module crcb_engine_chk
    import crcb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             msg_start,
    input logic             byte_vld,
    input logic [SYM_W-1:0] byte_in,
    input logic [CRC_W-1:0] crc_out
);
    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> crc_out == '0);

    // R4
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!msg_start && !byte_vld) |=> $stable(crc_out));

    // R5
    a_r5_start_clears: assert property (@(posedge clk) disable iff (rst)
        (msg_start && !byte_vld) |=> crc_out == '0);

    // R6
    a_r6_start_zero_byte: assert property (@(posedge clk) disable iff (rst)
        (msg_start && byte_vld && byte_in == 8'h00) |=> crc_out == '0);

    // R2
    a_r2_entry_one: assert property (@(posedge clk) disable iff (rst)
        (msg_start && byte_vld && byte_in == 8'h01) |=> crc_out == 16'h1021);

    // R3: a zero byte into a zero remainder keeps it zero
    a_r3_zero_fold: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !msg_start && byte_in == 8'h00 && crc_out == '0)
        |=> crc_out == '0);
endmodule

bind crcb_engine crcb_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_start (msg_start),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .crc_out   (crc_out)
);

// File: tb/tb_crcb_engine.sv
`timescale 1ns/1ps
module tb_crcb_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        msg_start;
    logic        byte_vld;
    logic [7:0]  byte_in;
    logic [15:0] crc_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] model = 16'h0000;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crcb_engine dut (
        .clk       (clk),
        .rst       (rst),
        .msg_start (msg_start),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .crc_out   (crc_out)
    );

    function automatic logic [15:0] serial_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ b[i];
            r  = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_cmp++;
        if (crc_out !== exp) begin
            n_bad++;
            $display("FAIL %s: crc_out=%h expected=%h", tag, crc_out, exp);
        end
    endtask

    // One clock of stimulus: model update, then compare after the edge.
    task automatic step(input logic s, input logic v, input logic [7:0] b, input string tag);
        @(negedge clk);
        msg_start = s;
        byte_vld  = v;
        byte_in   = b;
        if (s) model = 16'h0000;
        if (v) model = serial_byte(model, b);
        @(posedge clk);
        #1;
        check(tag, model);
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: crc_out=%h expected=done", crc_out);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] msg_crc;
        logic [7:0]  digits [9];
        int unsigned seed;
        seed = 32'h5eed_1234;
        rst = 1'b1; msg_start = 1'b0; byte_vld = 1'b0; byte_in = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after release", 16'h0000);

        // R2: single bytes from a fresh start read table entries
        step(1'b1, 1'b1, 8'h00, "R2 entry0");
        check("R2 entry0 literal", 16'h0000);
        step(1'b1, 1'b1, 8'h01, "R2 entry1");
        check("R2 entry1 literal", 16'h1021);
        step(1'b1, 1'b1, 8'h02, "R2 entry2");
        check("R2 entry2 literal", 16'h2042);
        step(1'b1, 1'b1, 8'h03, "R2 entry3");
        check("R2 entry3 literal", 16'h3063);
        for (int j = 0; j < 256; j++) step(1'b1, 1'b1, 8'(j), "R2 sweep");

        // R8: standard check string
        digits = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        step(1'b1, 1'b0, 8'h00, "R5 start only");
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1, digits[i], "R3 digits");
        check("R8 check value", 16'h31C3);

        // R4: idle cycles hold a nonzero remainder
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'hA5 ^ 8'(i), "R4 idle hold");

        // R7: append own result, high byte first
        msg_crc = crc_out;
        step(1'b0, 1'b1, msg_crc[15:8], "R7 high");
        step(1'b0, 1'b1, msg_crc[7:0], "R7 low");
        check("R7 zero residue", 16'h0000);

        // R3/R4/R5/R6: random bursts with gaps, starts on nonzero state
        for (int m = 0; m < 40; m++) begin
            for (int i = 0; i < 30; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                step(1'b0, seed[16], seed[27:20], "R3 R4 burst");
            end
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[18]) step(1'b1, 1'b0, seed[27:20], "R5 start clears");
            else          step(1'b1, 1'b1, seed[27:20], "R6 start with byte");
        end

        // R7 on a random message
        step(1'b1, 1'b0, 8'h00, "R5 start before R7");
        for (int i = 0; i < 50; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(1'b0, 1'b1, seed[27:20], "R3 message");
        end
        msg_crc = crc_out;
        step(1'b0, 1'b1, msg_crc[15:8], "R7 high");
        step(1'b0, 1'b1, msg_crc[7:0], "R7 low");
        check("R7 zero residue random", 16'h0000);

        // R1 again: reset mid-message
        @(negedge clk);
        rst = 1'b1; byte_vld = 1'b1; byte_in = 8'h77;
        @(posedge clk);
        #1;
        model = 16'h0000;
        check("R1 reset wins", 16'h0000);
        @(negedge clk);
        rst = 1'b0; byte_vld = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule